// File: doc/BRIEF.md
# Supply Reset Generator with Delay

This block turns digital supply-monitor flags into an active-low reset for a microcontroller. It asserts reset when the regulated output falls below its reset threshold, when the input supply sags, or when a watchdog asks for a reset. Each of these conditions holds reset low for as long as it lasts. Once every condition has cleared, reset stays low for a further delay before it is released.

Two time-base ticks drive the timing. A fast tick qualifies output undervoltage, so that a short dip is ignored. A slow, millisecond-scale tick counts the release delay. Two mode pins choose a short or a long delay. When the output is too low to be valid, both the pull-up and the pull-down of the reset pin are switched off, so the pin floats instead of being driven. A one-cycle pulse marks each release, for use by the watchdog.

Top module: `supply_reset_gen`

## Requirements
- R1: While the synchronous-logic reset `rst_n` is low, and on the first cycle after it, `rst_out_n` is 0 and `release_pulse` is 0.
- R2: If `out_uv` stays at 1 through `GLITCH_TICKS` consecutive `fast_tick` pulses, `rst_out_n` is 0 on the clock edge after the qualifying tick edge. It stays 0 while `out_uv` remains 1.
- R3: If `out_uv` returns to 0 before `GLITCH_TICKS` fast ticks have been seen, the dip is ignored: `rst_out_n` stays 1. Any 0 on `out_uv` restarts the tick count from zero.
- R4: `in_uv` at 1 on a clock edge makes `rst_out_n` 0 after that edge. No qualification is applied.
- R5: `wd_req` at 1 on a clock edge makes `rst_out_n` 0 after that edge. Release then follows the normal delay.
- R6: Once all hold conditions are clear, `rst_out_n` rises on the edge that consumes the N-th `slow_tick`. N is `FAST_DELAY` when `{mode_a, mode_b}` = 2'b00. N is `SLOW_DELAY` for 2'b01, 2'b10 and 2'b11.
- R7: Any hold condition arriving during the delay restarts the delay count from zero.
- R8: While `out_valid` is 0, `pullup_en` and `sink_en` are both 0, so the pin floats, and the logical reset is held. While `out_valid` is 1, `pullup_en` is 1 and `sink_en` equals the inverse of `rst_out_n`.
- R9: `release_pulse` is 1 for exactly the one cycle in which `rst_out_n` first reads 1 after being 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| fast_tick | input | 1 | One-cycle pulse of the glitch-qualifier time base |
| slow_tick | input | 1 | One-cycle pulse of the delay time base |
| out_uv | input | 1 | Output below reset threshold |
| in_uv | input | 1 | Input supply below its threshold |
| out_valid | input | 1 | Output above the minimum for driving the pin |
| mode_a | input | 1 | Timing-mode select pin A |
| mode_b | input | 1 | Timing-mode select pin B |
| wd_req | input | 1 | Watchdog timeout reset request |
| rst_out_n | output | 1 | Logical reset level, active low |
| sink_en | output | 1 | Enable of the pin pull-down driver |
| pullup_en | output | 1 | Enable of the pin pull-up |
| release_pulse | output | 1 | One-cycle marker of reset release |

## Verification
The bench counts slow ticks up to release for all four mode-pin codes. A design that decodes the mode pins wrongly releases after the wrong count. It sends `out_uv` dips that are one tick short of qualifying, including two short dips back to back. A qualifier that does not clear between dips would assert reset on these. It interrupts a running delay partway through and expects a full delay afterwards, which catches a timer that resumes instead of restarting. It also drops `out_valid` and checks that both pin drivers turn off while the logical reset stays asserted.

// File: rtl/srg_pkg.sv
package srg_pkg;
  // Delay length in slow ticks for a mode-pin code: only 00 picks the short delay.
  function automatic int unsigned delay_limit(input logic ma, input logic mb,
                                              input int unsigned short_len,
                                              input int unsigned long_len);
    return (!ma && !mb) ? short_len : long_len;
  endfunction
endpackage

// File: rtl/srg_glitch_qual.sv
module srg_glitch_qual #(
  parameter int unsigned TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic qual
);
  localparam int unsigned QW = $clog2(TICKS + 1);
  logic [QW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (!raw)                      cnt <= '0;
    else if (tick && cnt != QW'(TICKS)) cnt <= cnt + QW'(1);
  end

  assign qual = (cnt == QW'(TICKS));
endmodule

// File: rtl/srg_delay_ctr.sv
module srg_delay_ctr #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          released,
  output logic          rel_pulse,
  output logic [CW-1:0] cnt
);
  logic last_tick;
  assign last_tick = (cnt + CW'(1)) >= limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      released  <= 1'b0;
      rel_pulse <= 1'b0;
    end else begin
      rel_pulse <= 1'b0;
      if (hold) begin
        cnt      <= '0;
        released <= 1'b0;
      end else if (!released && tick) begin
        if (last_tick) begin
          cnt       <= '0;
          released  <= 1'b1;
          rel_pulse <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen #(
  parameter int unsigned GLITCH_TICKS = 3,
  parameter int unsigned FAST_DELAY   = 16,
  parameter int unsigned SLOW_DELAY   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_tick,
  input  logic slow_tick,
  input  logic out_uv,
  input  logic in_uv,
  input  logic out_valid,
  input  logic mode_a,
  input  logic mode_b,
  input  logic wd_req,
  output logic rst_out_n,
  output logic sink_en,
  output logic pullup_en,
  output logic release_pulse
);
  localparam int unsigned MAXD = (FAST_DELAY > SLOW_DELAY) ? FAST_DELAY : SLOW_DELAY;
  localparam int unsigned CW   = $clog2(MAXD + 1);

  logic          uv_qual;
  logic          hold_any;
  logic [CW-1:0] dly_limit;
  logic [CW-1:0] dly_cnt;
  logic          released;

  srg_glitch_qual #(.TICKS(GLITCH_TICKS)) u_qual (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (fast_tick),
    .raw  (out_uv),
    .qual (uv_qual)
  );

  assign hold_any  = uv_qual | in_uv | wd_req | ~out_valid;
  assign dly_limit = CW'(srg_pkg::delay_limit(mode_a, mode_b, FAST_DELAY, SLOW_DELAY));

  srg_delay_ctr #(.CW(CW)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold_any),
    .tick     (slow_tick),
    .limit    (dly_limit),
    .released (released),
    .rel_pulse(release_pulse),
    .cnt      (dly_cnt)
  );

  assign rst_out_n = released;
  assign pullup_en = out_valid;
  assign sink_en   = out_valid & ~released;
endmodule

// File: rtl/supply_reset_gen_chk.sv
module supply_reset_gen_chk #(
  parameter int unsigned CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_uv,
  input logic          in_uv,
  input logic          wd_req,
  input logic          out_valid,
  input logic          rst_out_n,
  input logic          sink_en,
  input logic          pullup_en,
  input logic          release_pulse,
  input logic          uv_qual,
  input logic          hold_any,
  input logic [CW-1:0] dly_cnt
);
  a_r2_qual_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
    uv_qual |=> !rst_out_n);
  a_r3_qual_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uv_qual) |-> $past(out_uv));
  a_r4_in_uv_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
    in_uv |=> !rst_out_n);
  a_r5_wd_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
    wd_req |=> !rst_out_n);
  a_r6_release_only_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> $past(!hold_any));
  a_r7_hold_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    hold_any |=> (dly_cnt == '0));
  a_r8_float_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!pullup_en && !sink_en));
  a_r9_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> release_pulse);
  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |=> !release_pulse);
endmodule

bind supply_reset_gen supply_reset_gen_chk #(.CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .out_uv       (out_uv),
  .in_uv        (in_uv),
  .wd_req       (wd_req),
  .out_valid    (out_valid),
  .rst_out_n    (rst_out_n),
  .sink_en      (sink_en),
  .pullup_en    (pullup_en),
  .release_pulse(release_pulse),
  .uv_qual      (uv_qual),
  .hold_any     (hold_any),
  .dly_cnt      (dly_cnt)
);

// File: tb/supply_reset_gen_bench.sv
`timescale 1ns/1ps
module supply_reset_gen_bench;
  localparam int GT = 3;
  localparam int FD = 16;
  localparam int SD = 32;
  // {mode_a, mode_b, expected delay[5:0]}
  localparam logic [7:0] VEC [4] = '{
    {1'b0, 1'b0, 6'(FD)}, {1'b0, 1'b1, 6'(SD)},
    {1'b1, 1'b0, 6'(SD)}, {1'b1, 1'b1, 6'(SD)}
  };

  logic clk = 0, rst_n = 0, fast_tick = 0, slow_tick = 0, out_uv = 0, in_uv = 0;
  logic out_valid = 1, mode_a = 0, mode_b = 0, wd_req = 0;
  logic rst_out_n, sink_en, pullup_en, release_pulse;
  int n_vec = 0, n_bad = 0, got;
  bit done = 0;

  always #4 clk = ~clk;

  supply_reset_gen #(.GLITCH_TICKS(GT), .FAST_DELAY(FD), .SLOW_DELAY(SD)) u_supply_reset_gen (
    .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
    .out_uv(out_uv), .in_uv(in_uv), .out_valid(out_valid), .mode_a(mode_a),
    .mode_b(mode_b), .wd_req(wd_req), .rst_out_n(rst_out_n), .sink_en(sink_en),
    .pullup_en(pullup_en), .release_pulse(release_pulse));

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ftick();
    @(negedge clk) fast_tick = 1;
    @(negedge clk) fast_tick = 0;
  endtask

  task automatic stick();
    @(negedge clk) slow_tick = 1;
    @(negedge clk) slow_tick = 0;
  endtask

  task automatic pulse_wd();
    @(negedge clk) wd_req = 1;
    @(negedge clk) wd_req = 0;
  endtask

  // Count slow ticks until release; checks the release pulse in the same sample.
  task automatic run_delay(input string req, output int n);
    n = 0;
    for (int k = 1; k <= 80; k++) begin
      stick();
      if (rst_out_n === 1'b1) begin
        n = k;
        chk("R9 pulse at release", int'(release_pulse), 1);
        @(negedge clk);
        chk("R9 pulse one cycle", int'(release_pulse), 0);
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset level", int'(rst_out_n), 0);
    chk("R1 pulse", int'(release_pulse), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", int'(rst_out_n), 0);

    for (int i = 0; i < 4; i++) begin
      mode_a = VEC[i][7];
      mode_b = VEC[i][6];
      pulse_wd();
      chk("R5 watchdog request", int'(rst_out_n), 0);
      chk("R8 sink while reset", int'(sink_en), 1);
      run_delay("R6", got);
      chk("R6 delay by mode", got, int'(VEC[i][5:0]));
    end
    mode_a = 0; mode_b = 0;

    // R4: input undervoltage, one cycle, unqualified
    @(negedge clk) in_uv = 1;
    @(negedge clk) in_uv = 0;
    chk("R4 input undervoltage", int'(rst_out_n), 0);
    run_delay("R4", got);
    chk("R4 delay after", got, FD);

    // R3: two short dips, each one tick short
    @(negedge clk) out_uv = 1;
    repeat (GT - 1) ftick();
    @(negedge clk) out_uv = 0;
    @(negedge clk) out_uv = 1;
    repeat (GT - 1) ftick();
    @(negedge clk) out_uv = 0;
    repeat (2) @(negedge clk);
    chk("R3 short dips ignored", int'(rst_out_n), 1);

    // R2: qualified undervoltage
    @(negedge clk) out_uv = 1;
    repeat (GT) ftick();
    @(negedge clk);
    chk("R2 qualified undervoltage", int'(rst_out_n), 0);
    repeat (3) stick();
    chk("R2 held while low", int'(rst_out_n), 0);
    @(negedge clk) out_uv = 0;
    run_delay("R2", got);
    chk("R2 delay after", got, FD);

    // R7: interrupt a running delay
    pulse_wd();
    repeat (10) stick();
    chk("R7 still in delay", int'(rst_out_n), 0);
    @(negedge clk) in_uv = 1;
    @(negedge clk) in_uv = 0;
    run_delay("R7", got);
    chk("R7 full delay after restart", got, FD);

    // R8: output not valid -> pin floats
    @(negedge clk) out_valid = 0;
    @(negedge clk);
    chk("R8 pullup off", int'(pullup_en), 0);
    chk("R8 sink off", int'(sink_en), 0);
    chk("R8 reset held", int'(rst_out_n), 0);
    @(negedge clk) out_valid = 1;
    @(negedge clk);
    chk("R8 pullup on", int'(pullup_en), 1);
    chk("R8 sink on", int'(sink_en), 1);
    run_delay("R8", got);
    chk("R8 delay after", got, FD);
    chk("R8 sink released", int'(sink_en), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule